// File: doc/BRIEF.md
# Scan Address Self-Check Controller

This controller supervises a channel-address RAM that is read once per scan. A diagnostic generator produces a second copy of the channel address, and the controller compares the two copies. Three conditions raise a fault: a live address disagreement, an end-of-scan pulse that never arrives, or an external error input. A fault forces the functional RAM through a rewrite that lasts exactly one scan, and the controller then returns that RAM to normal reading.

The diagnostic RAM alternates between a write scan and a read scan on every end-of-scan pulse. The comparator is gated off whenever its result could be false: before the first diagnostic read scan, during every diagnostic write scan, and while the functional RAM is being rewritten. All activity is qualified by a one-cycle system strobe (`strobe`), and scan boundaries are marked by a one-cycle `eos` pulse. The RAMs and the address generators are outside this block.

The functional side is a three-state machine:
- FN_READ goes to FN_PENDING when a fault is present on a strobe cycle.
- FN_PENDING goes to FN_WRITE on `eos`.
- FN_WRITE goes to FN_READ on `eos`.

The diagnostic side is a three-state machine:
- DG_PRIME is a read scan with the comparator held off. It goes to DG_WRITE on `eos`.
- DG_WRITE goes to DG_CHECK on `eos`.
- DG_CHECK goes to DG_WRITE on `eos`.

Top module: `scanchk_ctrl`

## Requirements
- R1: A synchronous active-high `rst` leaves, from the next cycle: both RAM paths in read mode (`fram_sel_wr`=0, `dram_sel_wr`=0), the comparator off (`cmp_live`=0), `mismatch`=0, and the diagnostic side in DG_PRIME.
- R2: The diagnostic phase changes on every `eos` and only on `eos`, in the order DG_PRIME, DG_WRITE, DG_CHECK, DG_WRITE, and so on. `dram_sel_wr`=1 exactly in DG_WRITE. In DG_WRITE, `dram_we` equals `strobe`; otherwise `dram_re` equals `strobe`.
- R3: `cmp_live` is 1 exactly when the diagnostic side is in DG_CHECK and the functional side is not in FN_WRITE.
- R4: On each strobe cycle, `mismatch` is loaded with (`cmp_live` and `func_addr`≠`diag_addr`). Between strobes it holds its value.
- R5: In FN_READ, a strobe cycle with `cmp_live`=1 and unequal addresses moves the functional side to FN_PENDING.
- R6: In FN_READ, a strobe cycle with `err_in`=1 moves the functional side to FN_PENDING.
- R7: A counter of strobes since the last `eos` clears on `eos` and saturates at SCAN_LEN. A strobe seen while the counter equals SCAN_LEN is a missing-scan fault, which moves FN_READ to FN_PENDING. Exactly SCAN_LEN strobes between `eos` pulses is not a fault.
- R8: FN_PENDING moves to FN_WRITE only on `eos`. Faults seen in FN_PENDING or FN_WRITE have no effect, and without a prior fault an `eos` leaves FN_READ unchanged.
- R9: In FN_WRITE, `fram_sel_wr`=1, `fram_we` equals `strobe` and `fram_re`=0. The next `eos` always returns the functional side to FN_READ, so a rewrite lasts one scan.
- R10: In FN_READ and FN_PENDING, `fram_sel_wr`=0, `fram_we`=0 and `fram_re` equals `strobe`.
- R11: Unequal addresses while `cmp_live`=0 (in DG_PRIME or DG_WRITE) leave `mismatch` at 0 and start no rewrite.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe | input | 1 | System clock strobe, one cycle wide |
| eos | input | 1 | End-of-scan pulse, one cycle wide |
| func_addr | input | ADDR_W | Functional channel address |
| diag_addr | input | ADDR_W | Diagnostic channel address |
| err_in | input | 1 | External error input |
| fram_we | output | 1 | Functional RAM write enable |
| fram_re | output | 1 | Functional RAM read enable |
| fram_sel_wr | output | 1 | Functional port selector: 1 selects the write address |
| dram_we | output | 1 | Diagnostic RAM write enable |
| dram_re | output | 1 | Diagnostic RAM read enable |
| dram_sel_wr | output | 1 | Diagnostic port selector: 1 selects the write address |
| cmp_live | output | 1 | Address comparator is enabled |
| mismatch | output | 1 | Registered mismatch flag, updated on each strobe |

## Verification
The bench builds the block with ADDR_W=4 and SCAN_LEN=6. The short scan length lets the missing-scan watchdog be driven to its limit, and one strobe past it, within a handful of cycles. The narrow address lets random stimulus hit equal and unequal addresses often. With these values, directed scans walk both state machines through every transition, including the boundary of exactly SCAN_LEN strobes. A random segment then mixes strobes, sparse end-of-scan pulses, address disagreements and errors against a behavioural model.

// File: rtl/scanchk_pkg.sv
package scanchk_pkg;

    // Functional RAM sequencing
    typedef enum logic [1:0] {
        FN_READ    = 2'd0,
        FN_PENDING = 2'd1,
        FN_WRITE   = 2'd2
    } fn_state_e;

    // Diagnostic RAM scan phase
    typedef enum logic [1:0] {
        DG_PRIME = 2'd0,
        DG_WRITE = 2'd1,
        DG_CHECK = 2'd2
    } dg_state_e;

    // Per-RAM port control bundle
    typedef struct packed {
        logic we;
        logic re;
        logic sel_wr;
    } port_ctl_t;

endpackage

// File: rtl/scanchk_watchdog.sv
module scanchk_watchdog #(
    parameter int SCAN_LEN = 1000,
    localparam int CNT_W = $clog2(SCAN_LEN + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    input  logic eos,
    output logic missing
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(SCAN_LEN);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (eos) begin
            cnt_q <= '0;
        end else if (strobe && (cnt_q != LIMIT)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        missing = (cnt_q == LIMIT);
    end
endmodule

// File: rtl/scanchk_diag_seq.sv
module scanchk_diag_seq
    import scanchk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      strobe,
    input  logic      eos,
    output port_ctl_t ctl,
    output logic      check_scan
);
    dg_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DG_PRIME: if (eos) state_d = DG_WRITE;
            DG_WRITE: if (eos) state_d = DG_CHECK;
            DG_CHECK: if (eos) state_d = DG_WRITE;
            default:  state_d = DG_PRIME;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= DG_PRIME;
        else     state_q <= state_d;
    end

    always_comb begin
        ctl        = '0;
        check_scan = 1'b0;
        unique case (state_q)
            DG_WRITE: begin
                ctl.we     = strobe;
                ctl.sel_wr = 1'b1;
            end
            DG_CHECK: begin
                ctl.re     = strobe;
                check_scan = 1'b1;
            end
            default: begin
                ctl.re = strobe;
            end
        endcase
    end
endmodule

// File: rtl/scanchk_func_fsm.sv
module scanchk_func_fsm
    import scanchk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      strobe,
    input  logic      eos,
    input  logic      fault,
    output port_ctl_t ctl,
    output logic      in_write
);
    fn_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FN_READ:    if (strobe && fault) state_d = FN_PENDING;
            FN_PENDING: if (eos)             state_d = FN_WRITE;
            FN_WRITE:   if (eos)             state_d = FN_READ;
            default:                         state_d = FN_READ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= FN_READ;
        else     state_q <= state_d;
    end

    always_comb begin
        ctl      = '0;
        in_write = 1'b0;
        unique case (state_q)
            FN_WRITE: begin
                ctl.we     = strobe;
                ctl.sel_wr = 1'b1;
                in_write   = 1'b1;
            end
            default: begin
                ctl.re = strobe;
            end
        endcase
    end
endmodule

// File: rtl/scanchk_compare.sv
module scanchk_compare #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  logic              live,
    input  logic [ADDR_W-1:0] func_addr,
    input  logic [ADDR_W-1:0] diag_addr,
    output logic              differ,
    output logic              flag
);
    logic [ADDR_W-1:0] bit_diff;

    for (genvar i = 0; i < ADDR_W; i++) begin : g_bitcmp
        assign bit_diff[i] = func_addr[i] ^ diag_addr[i];
    end

    always_comb begin
        differ = live && (|bit_diff);
    end

    always_ff @(posedge clk) begin
        if (rst)         flag <= 1'b0;
        else if (strobe) flag <= differ;
    end
endmodule

// File: rtl/scanchk_ctrl.sv
module scanchk_ctrl
    import scanchk_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int SCAN_LEN = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  logic              eos,
    input  logic [ADDR_W-1:0] func_addr,
    input  logic [ADDR_W-1:0] diag_addr,
    input  logic              err_in,
    output logic              fram_we,
    output logic              fram_re,
    output logic              fram_sel_wr,
    output logic              dram_we,
    output logic              dram_re,
    output logic              dram_sel_wr,
    output logic              cmp_live,
    output logic              mismatch
);
    port_ctl_t fctl, dctl;
    logic      check_scan, fn_writing, addr_differ, scan_missing, fault;

    scanchk_watchdog #(.SCAN_LEN(SCAN_LEN)) u_wdog (
        .clk(clk), .rst(rst), .strobe(strobe), .eos(eos), .missing(scan_missing)
    );

    scanchk_diag_seq u_diag (
        .clk(clk), .rst(rst), .strobe(strobe), .eos(eos),
        .ctl(dctl), .check_scan(check_scan)
    );

    scanchk_func_fsm u_func (
        .clk(clk), .rst(rst), .strobe(strobe), .eos(eos), .fault(fault),
        .ctl(fctl), .in_write(fn_writing)
    );

    scanchk_compare #(.ADDR_W(ADDR_W)) u_cmp (
        .clk(clk), .rst(rst), .strobe(strobe), .live(cmp_live),
        .func_addr(func_addr), .diag_addr(diag_addr),
        .differ(addr_differ), .flag(mismatch)
    );

    always_comb begin
        cmp_live    = check_scan && !fn_writing;
        fault       = addr_differ || scan_missing || err_in;
        fram_we     = fctl.we;
        fram_re     = fctl.re;
        fram_sel_wr = fctl.sel_wr;
        dram_we     = dctl.we;
        dram_re     = dctl.re;
        dram_sel_wr = dctl.sel_wr;
    end
endmodule

// File: rtl/scanchk_ctrl_sva.sv
module scanchk_ctrl_sva (
    input logic clk,
    input logic rst,
    input logic strobe,
    input logic eos,
    input logic fram_we,
    input logic fram_re,
    input logic fram_sel_wr,
    input logic dram_we,
    input logic dram_re,
    input logic dram_sel_wr,
    input logic cmp_live,
    input logic mismatch
);
    assert_phase_flips_R2: assert property (@(posedge clk) disable iff (rst)
        eos |=> (dram_sel_wr != $past(dram_sel_wr)));
    assert_phase_holds_R2: assert property (@(posedge clk) disable iff (rst)
        !eos |=> $stable(dram_sel_wr));
    assert_dram_ports_R2: assert property (@(posedge clk) disable iff (rst)
        !(dram_we && dram_re));
    assert_live_gated_R3: assert property (@(posedge clk) disable iff (rst)
        cmp_live |-> (!dram_sel_wr && !fram_sel_wr));
    assert_flag_holds_R4: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> $stable(mismatch));
    assert_flag_needs_live_R11: assert property (@(posedge clk) disable iff (rst)
        (strobe && !cmp_live) |=> !mismatch);
    assert_write_entry_eos_R8: assert property (@(posedge clk) disable iff (rst)
        !eos |=> !$rose(fram_sel_wr));
    assert_write_one_scan_R9: assert property (@(posedge clk) disable iff (rst)
        (fram_sel_wr && eos) |=> !fram_sel_wr);
    assert_write_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        fram_we |-> (strobe && fram_sel_wr));
    assert_read_ports_R10: assert property (@(posedge clk) disable iff (rst)
        fram_re |-> (strobe && !fram_sel_wr && !fram_we));
endmodule

bind scanchk_ctrl scanchk_ctrl_sva u_sva (
    .clk(clk), .rst(rst), .strobe(strobe), .eos(eos),
    .fram_we(fram_we), .fram_re(fram_re), .fram_sel_wr(fram_sel_wr),
    .dram_we(dram_we), .dram_re(dram_re), .dram_sel_wr(dram_sel_wr),
    .cmp_live(cmp_live), .mismatch(mismatch)
);

// File: tb/scanchk_ctrl_tb_top.sv
`timescale 1ns/1ps
module scanchk_ctrl_tb_top;
    localparam int AW = 4;
    localparam int SL = 6;

    logic clk = 1'b0, rst = 1'b1, strobe = 1'b0, eos = 1'b0, err_in = 1'b0;
    logic [AW-1:0] fa = '0, da = '0;
    logic fram_we, fram_re, fram_sel_wr, dram_we, dram_re, dram_sel_wr, cmp_live, mismatch;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    // behavioural model: f 0=read 1=pending 2=write; dw diag write scan; arm seen a check scan
    int m_f = 0, m_cnt = 0;
    bit m_dw = 0, m_arm = 0, m_mis = 0;

    always #2.5 clk = ~clk;

    scanchk_ctrl #(.ADDR_W(AW), .SCAN_LEN(SL)) dut_i (
        .clk(clk), .rst(rst), .strobe(strobe), .eos(eos),
        .func_addr(fa), .diag_addr(da), .err_in(err_in),
        .fram_we(fram_we), .fram_re(fram_re), .fram_sel_wr(fram_sel_wr),
        .dram_we(dram_we), .dram_re(dram_re), .dram_sel_wr(dram_sel_wr),
        .cmp_live(cmp_live), .mismatch(mismatch)
    );

    task automatic chk(string tag, string what, logic act, logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %b expected %b", tag, what, act, exp);
        end
    endtask

    task automatic drive(bit s, bit e, int a, int b, bit er);
        bit live, fault, wr;
        @(negedge clk);
        strobe = s; eos = e; fa = AW'(a); da = AW'(b); err_in = er;
        #1;
        live = !m_dw && m_arm && (m_f != 2);
        wr   = (m_f == 2);
        if (!rst) begin
            chk(wr ? "R9" : "R10", "fram_we", fram_we, wr && s);
            chk(wr ? "R9" : "R10", "fram_re", fram_re, !wr && s);
            chk(wr ? "R9" : "R10", "fram_sel_wr", fram_sel_wr, wr);
            chk("R2", "dram_we", dram_we, m_dw && s);
            chk("R2", "dram_re", dram_re, !m_dw && s);
            chk("R2", "dram_sel_wr", dram_sel_wr, m_dw);
            chk("R3", "cmp_live", cmp_live, live);
            chk("R4", "mismatch", mismatch, m_mis);
        end
        if (rst) begin
            m_f = 0; m_cnt = 0; m_dw = 0; m_arm = 0; m_mis = 0;
        end else begin
            fault = (live && (fa != da)) || (m_cnt == SL) || er;
            if (s) m_mis = live && (fa != da);
            if (m_f == 0) begin
                if (s && fault) m_f = 1;
            end else if (e) begin
                m_f = (m_f == 1) ? 2 : 0;
            end
            if (e) begin
                if (m_dw) m_arm = 1;
                m_dw = !m_dw;
                m_cnt = 0;
            end else if (s && m_cnt < SL) begin
                m_cnt++;
            end
        end
    endtask

    task automatic idle();
        drive(0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) idle();
        rst = 1'b0;
        // R1 reset state
        idle();
        chk("R1", "fram_sel_wr", fram_sel_wr, 1'b0);
        chk("R1", "dram_sel_wr", dram_sel_wr, 1'b0);
        chk("R1", "cmp_live", cmp_live, 1'b0);
        chk("R1", "mismatch", mismatch, 1'b0);
        drive(1, 0, 0, 0, 0);
        chk("R10", "fram_re on strobe", fram_re, 1'b1);

        // DG_PRIME: differing addresses are not live (R11)
        repeat (3) drive(1, 0, 1, 2, 0);
        idle();
        chk("R11", "mismatch in prime", mismatch, 1'b0);
        drive(0, 1, 0, 0, 0);
        idle();
        chk("R2", "phase now write", dram_sel_wr, 1'b1);
        chk("R11", "no rewrite after prime", fram_sel_wr, 1'b0);

        // DG_WRITE: still not live (R11)
        drive(1, 0, 1, 2, 0);
        chk("R2", "dram_we in write scan", dram_we, 1'b1);
        repeat (2) drive(1, 0, 1, 2, 0);
        idle();
        chk("R11", "mismatch in diag write", mismatch, 1'b0);
        chk("R3", "cmp off in diag write", cmp_live, 1'b0);
        drive(0, 1, 0, 0, 0);
        idle();
        chk("R3", "cmp live in check scan", cmp_live, 1'b1);
        chk("R11", "no rewrite after diag write", fram_sel_wr, 1'b0);

        // DG_CHECK: live mismatch (R5, R4, R8)
        repeat (2) drive(1, 0, 5, 5, 0);
        drive(1, 0, 5, 6, 0);
        idle();
        chk("R4", "flag set", mismatch, 1'b1);
        idle();
        chk("R4", "flag held between strobes", mismatch, 1'b1);
        drive(1, 0, 5, 5, 0);
        idle();
        chk("R4", "flag cleared on next strobe", mismatch, 1'b0);
        drive(1, 0, 0, 0, 1);
        idle();
        chk("R8", "no write before eos", fram_sel_wr, 1'b0);
        drive(0, 1, 0, 0, 0);
        idle();
        chk("R5", "rewrite entered", fram_sel_wr, 1'b1);
        chk("R3", "cmp off during rewrite", cmp_live, 1'b0);

        // FN_WRITE scan (R9)
        drive(1, 0, 3, 4, 1);
        chk("R9", "fram_we on strobe", fram_we, 1'b1);
        chk("R9", "fram_re off", fram_re, 1'b0);
        drive(1, 0, 3, 4, 1);
        drive(0, 1, 0, 0, 0);
        idle();
        chk("R9", "back to read after one scan", fram_sel_wr, 1'b0);

        // error input (R6)
        drive(1, 0, 7, 7, 1);
        drive(0, 1, 0, 0, 0);
        idle();
        chk("R6", "error forces rewrite", fram_sel_wr, 1'b1);
        drive(0, 1, 0, 0, 0);
        idle();
        chk("R9", "rewrite ended", fram_sel_wr, 1'b0);

        // watchdog boundary (R7)
        repeat (SL) drive(1, 0, 2, 2, 0);
        drive(0, 1, 0, 0, 0);
        idle();
        chk("R7", "exact scan length no fault", fram_sel_wr, 1'b0);
        repeat (SL + 1) drive(1, 0, 2, 2, 0);
        drive(0, 1, 0, 0, 0);
        idle();
        chk("R7", "missing eos forces rewrite", fram_sel_wr, 1'b1);
        drive(0, 1, 0, 0, 0);
        idle();
        chk("R9", "rewrite ended after watchdog", fram_sel_wr, 1'b0);

        // random mix compared against the model every cycle
        for (int i = 0; i < 600; i++) begin
            int a, b;
            a = $urandom_range(0, 3);
            b = ($urandom_range(0, 7) == 0) ? (a ^ 1) : a;
            drive($urandom_range(0, 1) == 1, $urandom_range(0, 11) == 0, a, b,
                  $urandom_range(0, 39) == 0);
        end

        // mid-run reset (R1)
        drive(0, 1, 0, 0, 0);
        rst = 1'b1;
        idle();
        rst = 1'b0;
        idle();
        chk("R1", "fram_sel_wr after reset", fram_sel_wr, 1'b0);
        chk("R1", "dram_sel_wr after reset", dram_sel_wr, 1'b0);
        chk("R1", "cmp_live after reset", cmp_live, 1'b0);
        chk("R1", "mismatch after reset", mismatch, 1'b0);
        drive(0, 1, 0, 0, 0);
        idle();
        chk("R2", "prime leads to write", dram_sel_wr, 1'b1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule